// File: doc/BRIEF.md
# Command Mailbox Register Interface

This block is the host-facing mailbox of a power-management controller. A host processor writes its input data into one or two 32-bit data registers, then writes a single interface register that packs a command byte, two parameter bytes and a start bit. The block forwards the command, the parameters and the data to a responder through a valid/ready request. It then waits for a done pulse that returns output data and an 8-bit error code.

While a command is in flight the interface register reads back with bit 31 set. When the responder finishes, the block does four things in the same update: it stores the returned data in the data registers, puts the error code in bits 7:0, clears bit 31 and pulses an interrupt for one cycle. A host that does not use the interrupt can poll bit 31 instead. The parameter `WIDE` selects between a payload of one data word and a payload of two data words.

Host registers are addressed by word: 0 is the low data word (byte offset 0x0), 1 is the high data word (byte offset 0x4) and 2 is the interface register.

Top module: `cmd_mailbox`

## Requirements
- R1: A write to the interface register (word address 2) with bit 31 set, while idle, starts a command, and bit 31 then reads as 1 until the command completes. A write with bit 31 clear has no effect.
- R2: The started command presents bits 7:0 of the written word on `rq_cmd`, bits 15:8 on `rq_arg1` and bits 23:16 on `rq_arg2`, with `rq_valid` high from the cycle after the write.
- R3: `rq_valid` and all request fields hold steady until `rq_ready` is seen high, and each command produces exactly one accepted request.
- R4: The low data word sits at word address 0 and the high word at word address 1. `rq_data` carries {high, low}. On completion `rs_data` replaces both registers.
- R5: On completion, bits 7:0 of the interface register read as `rs_err` and bit 31 reads 0. Code 0 means success, and codes 1 to 6 mean invalid command, invalid parameter, timeout, locked, invalid regulator id and regulator fault. Starting a command clears the error byte to 0.
- R6: While busy, writes to the interface register and writes to the data registers are ignored.
- R7: `irq` is high for exactly one cycle, namely the first cycle in which bit 31 reads back clear after a completion.
- R8: An `rs_done` pulse while idle, or before the request is accepted, is ignored: it raises no `irq`, changes no data and leaves bit 31 as it is.
- R9: After reset, bit 31, the error byte, both data registers, `rq_valid` and `irq` are all 0.
- R10: With `WIDE` = 0 only the low word exists. Writes to word address 1 are ignored and reads of it return 0.
- R11: Read data appears on `hb_rdata` in the cycle after `hb_ren`. Interface bits 30:8 read 0, and an unmapped word address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hb_wen | input | 1 | Host write strobe |
| hb_ren | input | 1 | Host read strobe |
| hb_addr | input | AW | Host word address |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, registered |
| rq_valid | output | 1 | Request valid to responder |
| rq_ready | input | 1 | Responder accepts request |
| rq_cmd | output | 8 | Command code |
| rq_arg1 | output | 8 | First parameter byte |
| rq_arg2 | output | 8 | Second parameter byte |
| rq_data | output | 32*(WIDE+1) | Input data words, high word above low |
| rs_done | input | 1 | Responder completion pulse |
| rs_data | input | 32*(WIDE+1) | Output data returned by responder |
| rs_err | input | 8 | Error code returned by responder |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest window to reach is the one between the start write and the acceptance of the request. In that window the block is busy but not yet waiting for a result, so a stray done pulse, a second start write and data writes must all be shown to do nothing. The bench holds `rq_ready` low after a start and drives all three stimuli inside that window. It then reads the interface and data registers back, and compares the request fields, before it finally accepts and completes the command. It also replays every failure code and checks that the next start wipes the error byte.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} mbx_state_e;

  typedef enum logic [7:0] {
    ERR_OK         = 8'd0,
    ERR_BAD_CMD    = 8'd1,
    ERR_BAD_ARG    = 8'd2,
    ERR_TIMEOUT    = 8'd3,
    ERR_LOCKED     = 8'd4,
    ERR_BAD_RAIL   = 8'd5,
    ERR_RAIL_FAULT = 8'd6
  } mbx_err_e;

  localparam int ADDR_LO = 0;
  localparam int ADDR_HI = 1;
  localparam int ADDR_IF = 2;
  localparam int RUN_BIT = 31;
endpackage

// File: rtl/mbx_data.sv
module mbx_data #(
  parameter int NW = 2,
  parameter int AW = 2,
  localparam int DW = 32 * NW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] words
);
  for (genvar k = 0; k < NW; k++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)
        word_q <= '0;
      else if (load)
        word_q <= load_data[32*k +: 32];
      else if (wr_en && wr_addr == AW'(k))
        word_q <= wr_data;
    end
    assign words[32*k +: 32] = word_q;
  end
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        if_wr,
  input  logic        if_run,
  input  logic [23:0] if_fields,
  output logic        rq_valid,
  input  logic        rq_ready,
  output logic [7:0]  rq_cmd,
  output logic [7:0]  rq_arg1,
  output logic [7:0]  rq_arg2,
  input  logic        rs_done,
  input  logic [7:0]  rs_err,
  output logic        busy,
  output logic [7:0]  err,
  output logic        load,
  output logic        irq
);
  mbx_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      busy    <= 1'b0;
      err     <= ERR_OK;
      irq     <= 1'b0;
      rq_cmd  <= '0;
      rq_arg1 <= '0;
      rq_arg2 <= '0;
    end else begin
      irq <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (if_wr && if_run) begin
          rq_cmd  <= if_fields[7:0];
          rq_arg1 <= if_fields[15:8];
          rq_arg2 <= if_fields[23:16];
          err     <= ERR_OK;
          busy    <= 1'b1;
          state_q <= ST_REQ;
        end
        ST_REQ: if (rq_ready) state_q <= ST_WAIT;
        ST_WAIT: if (rs_done) begin
          err     <= rs_err;
          busy    <= 1'b0;
          irq     <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rq_valid = (state_q == ST_REQ);
  assign load     = (state_q == ST_WAIT) && rs_done;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter bit WIDE = 1'b1,
  parameter int AW   = 2,
  localparam int NW  = WIDE ? 2 : 1,
  localparam int DW  = 32 * NW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hb_wen,
  input  logic          hb_ren,
  input  logic [AW-1:0] hb_addr,
  input  logic [31:0]   hb_wdata,
  output logic [31:0]   hb_rdata,
  output logic          rq_valid,
  input  logic          rq_ready,
  output logic [7:0]    rq_cmd,
  output logic [7:0]    rq_arg1,
  output logic [7:0]    rq_arg2,
  output logic [DW-1:0] rq_data,
  input  logic          rs_done,
  input  logic [DW-1:0] rs_data,
  input  logic [7:0]    rs_err,
  output logic          irq
);
  logic        busy;
  logic        load;
  logic [7:0]  err;
  logic        if_wr;
  logic        dat_wr;
  logic [31:0] rd_next;

  assign if_wr  = hb_wen && (hb_addr == AW'(ADDR_IF)) && !busy;
  assign dat_wr = hb_wen && !busy;

  mbx_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .if_wr(if_wr), .if_run(hb_wdata[RUN_BIT]), .if_fields(hb_wdata[23:0]),
    .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_cmd(rq_cmd), .rq_arg1(rq_arg1), .rq_arg2(rq_arg2),
    .rs_done(rs_done), .rs_err(rs_err),
    .busy(busy), .err(err), .load(load), .irq(irq)
  );

  mbx_data #(.NW(NW), .AW(AW)) u_data (
    .clk(clk), .rst(rst),
    .wr_en(dat_wr), .wr_addr(hb_addr), .wr_data(hb_wdata),
    .load(load), .load_data(rs_data), .words(rq_data)
  );

  always_comb begin
    rd_next = '0;
    if (hb_addr == AW'(ADDR_IF))
      rd_next = {busy, 23'd0, err};
    for (int k = 0; k < NW; k++)
      if (hb_addr == AW'(k)) rd_next = rq_data[32*k +: 32];
  end

  always_ff @(posedge clk) begin
    if (rst)         hb_rdata <= '0;
    else if (hb_ren) hb_rdata <= rd_next;
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int DW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          irq,
  input logic          rq_valid,
  input logic          rq_ready,
  input logic [7:0]    rq_cmd,
  input logic [7:0]    rq_arg1,
  input logic [7:0]    rq_arg2,
  input logic [DW-1:0] rq_data,
  input logic          rs_done
);
  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R7
  busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> irq);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable({rq_cmd, rq_arg1, rq_arg2, rq_data})));

  // R1
  valid_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rq_valid |-> busy);

  // R6
  data_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(rq_data) || irq));

  // R8
  idle_done_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && rs_done) |=> !irq);
endmodule

bind cmd_mailbox mbx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .irq(irq),
  .rq_valid(rq_valid), .rq_ready(rq_ready),
  .rq_cmd(rq_cmd), .rq_arg1(rq_arg1), .rq_arg2(rq_arg2),
  .rq_data(rq_data), .rs_done(rs_done)
);

// File: tb/test_cmd_mailbox.sv
module test_cmd_mailbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hb_wen = 1'b0, hb_ren = 1'b0, n_wen = 1'b0;
  logic [1:0]  hb_addr = '0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata, n_rdata;
  logic        rq_valid, rq_ready = 1'b0;
  logic [7:0]  rq_cmd, rq_arg1, rq_arg2;
  logic [63:0] rq_data;
  logic        rs_done = 1'b0;
  logic [63:0] rs_data = '0;
  logic [7:0]  rs_err = '0;
  logic        irq;
  logic        n_valid, n_irq;
  logic [7:0]  n_cmd, n_a1, n_a2;
  logic [31:0] n_data;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cmd_mailbox #(.WIDE(1'b1)) i_cmd_mailbox (
    .clk(clk), .rst(rst), .hb_wen(hb_wen), .hb_ren(hb_ren), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .rq_valid(rq_valid), .rq_ready(rq_ready),
    .rq_cmd(rq_cmd), .rq_arg1(rq_arg1), .rq_arg2(rq_arg2), .rq_data(rq_data),
    .rs_done(rs_done), .rs_data(rs_data), .rs_err(rs_err), .irq(irq));

  cmd_mailbox #(.WIDE(1'b0)) i_narrow (
    .clk(clk), .rst(rst), .hb_wen(n_wen), .hb_ren(hb_ren), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(n_rdata), .rq_valid(n_valid), .rq_ready(1'b1),
    .rq_cmd(n_cmd), .rq_arg1(n_a1), .rq_arg2(n_a2), .rq_data(n_data),
    .rs_done(1'b0), .rs_data(32'd0), .rs_err(8'd0), .irq(n_irq));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d, bit narrow = 1'b0);
    @(negedge clk);
    hb_addr = a; hb_wdata = d;
    if (narrow) n_wen = 1'b1; else hb_wen = 1'b1;
    @(negedge clk);
    hb_wen = 1'b0; n_wen = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v, output logic [31:0] nv);
    @(negedge clk);
    hb_addr = a; hb_ren = 1'b1;
    @(negedge clk);
    hb_ren = 1'b0;
    v = hb_rdata; nv = n_rdata;
  endtask

  task automatic launch(logic [7:0] c, logic [7:0] a1, logic [7:0] a2);
    wr(2'd2, {1'b1, 7'd0, a2, a1, c});
  endtask

  task automatic accept();
    while (!rq_valid) @(negedge clk);
    rq_ready = 1'b1;
    @(negedge clk);
    rq_ready = 1'b0;
  endtask

  task automatic finish_cmd(logic [63:0] d, logic [7:0] e);
    rs_done = 1'b1; rs_data = d; rs_err = e;
    @(negedge clk);
    rs_done = 1'b0;
    check("R7 irq raised", irq, 1);
    @(negedge clk);
    check("R7 irq one cycle", irq, 0);
  endtask

  task automatic t_reset();
    logic [31:0] v, nv;
    rd(2'd2, v, nv); check("R9 iface after reset", v, 0);
    rd(2'd0, v, nv); check("R9 low word after reset", v, 0);
    rd(2'd1, v, nv); check("R9 high word after reset", v, 0);
    check("R9 rq_valid after reset", rq_valid, 0);
    check("R9 irq after reset", irq, 0);
  endtask

  task automatic t_narrow();
    logic [31:0] v, nv;
    wr(2'd0, 32'hA5A5_0F0F, 1'b1);
    wr(2'd1, 32'h1234_5678, 1'b1);
    rd(2'd0, v, nv); check("R10 narrow low word", nv, 32'hA5A5_0F0F);
    rd(2'd1, v, nv); check("R10 narrow high word reads 0", nv, 0);
    check("R10 narrow data port", n_data, 32'hA5A5_0F0F);
  endtask

  task automatic t_roundtrip();
    logic [31:0] v, nv;
    wr(2'd0, 32'h1111_2222);
    wr(2'd1, 32'h3333_4444);
    launch(8'h5C, 8'h7E, 8'h81);
    check("R2 rq_valid after start", rq_valid, 1);
    check("R2 command byte", rq_cmd, 8'h5C);
    check("R2 first parameter", rq_arg1, 8'h7E);
    check("R2 second parameter", rq_arg2, 8'h81);
    check("R4 request data", rq_data, 64'h3333_4444_1111_2222);
    rd(2'd2, v, nv); check("R1 busy while running", v, 32'h8000_0000);
    accept();
    check("R3 valid drops after accept", rq_valid, 0);
    rd(2'd2, v, nv); check("R1 busy while waiting", v, 32'h8000_0000);
    finish_cmd(64'hDEAD_BEEF_CAFE_F00D, 8'd0);
    rd(2'd2, v, nv); check("R5 success status", v, 0);
    rd(2'd0, v, nv); check("R4 returned low word", v, 32'hCAFE_F00D);
    rd(2'd1, v, nv); check("R4 returned high word", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_busy_window();
    logic [31:0] v, nv;
    wr(2'd0, 32'h0000_00AA);
    launch(8'h11, 8'h01, 8'h02);
    wr(2'd2, 32'h8000_0022);
    wr(2'd0, 32'h0000_00BB);
    wr(2'd1, 32'h0000_00CC);
    check("R6 command kept while busy", rq_cmd, 8'h11);
    check("R6 data kept while busy", rq_data[31:0], 32'h0000_00AA);
    @(negedge clk); rs_done = 1'b1; rs_err = 8'd5;
    @(negedge clk); rs_done = 1'b0;
    check("R8 early done no irq", irq, 0);
    rd(2'd2, v, nv); check("R8 early done keeps busy", v, 32'h8000_0000);
    check("R3 valid held while not ready", rq_valid, 1);
    accept();
    finish_cmd(64'h0000_0007_0000_0009, 8'd0);
    rd(2'd0, v, nv); check("R4 load after busy window", v, 32'h0000_0009);
  endtask

  task automatic t_errors();
    logic [31:0] v, nv;
    for (int e = 1; e <= 6; e++) begin
      launch(8'(e), 8'h00, 8'h00);
      accept();
      finish_cmd(64'd0, 8'(e));
      rd(2'd2, v, nv); check("R5 failure code", v, 32'(e));
    end
    launch(8'h40, 8'h00, 8'h00);
    rd(2'd2, v, nv); check("R5 error cleared at start", v, 32'h8000_0000);
    accept();
    finish_cmd(64'd0, 8'd0);
  endtask

  task automatic t_stall();
    launch(8'h66, 8'h77, 8'h88);
    repeat (5) @(negedge clk);
    check("R3 valid stays while stalled", rq_valid, 1);
    check("R3 fields stay while stalled", {rq_cmd, rq_arg1, rq_arg2}, 24'h667788);
    accept();
    repeat (2) @(negedge clk);
    check("R3 single request", rq_valid, 0);
    finish_cmd(64'd0, 8'd0);
  endtask

  task automatic t_misc();
    logic [31:0] v, nv;
    wr(2'd2, 32'h00FF_FF99);
    check("R1 no start without run bit", rq_valid, 0);
    rd(2'd2, v, nv); check("R1 idle after plain write", v, 0);
    wr(2'd0, 32'h5555_AAAA);
    @(negedge clk); rs_done = 1'b1; rs_data = 64'hFFFF_FFFF_FFFF_FFFF; rs_err = 8'd3;
    @(negedge clk); rs_done = 1'b0;
    check("R8 idle done no irq", irq, 0);
    rd(2'd0, v, nv); check("R8 idle done keeps data", v, 32'h5555_AAAA);
    rd(2'd2, v, nv); check("R8 idle done keeps status", v, 0);
    rd(2'd3, v, nv); check("R11 unmapped reads zero", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_narrow();
    t_roundtrip();
    t_busy_window();
    t_errors();
    t_stall();
    t_misc();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule